// File: doc/BRIEF.md
# Interval Error Counter Bank with Tick Snapshots

This block counts link error events across a set of lanes and a handful of link-wide sources. Each source has a private accumulator that runs for one measurement interval. A performance-monitor tick ends the interval. On that edge every accumulator hands its value to a read-only snapshot register and restarts. Software therefore always reads a complete, frozen count for the last interval, and never a value that is still moving.

Three error kinds are counted per lane: bad block type, CRC mismatch and framing loss. Five more counters have one instance each: receive burst, general receive, missing end-of-packet, missing start-of-packet and transmit burst. The snapshots are read through a plain address / read-data port with a 4-byte word stride. The read data is registered. A synchronous clear pulse empties every accumulator and snapshot.

Each counter cell makes one decision per cycle and picks one of five named operations. The priority order is: OP_CLEAR (clear pulse), then OP_TICK_EVENT (tick with an event), then OP_TICK (tick alone), then OP_EVENT (event alone), then OP_IDLE (hold). The cell moves from any operation to any other on the next edge. Only its inputs in that cycle choose the operation.

Top module: `tick_err_counters`

## Requirements
- R1: While rst_n is low, and after it rises, every accumulator and snapshot is zero and rd_data_o reads zero.
- R2: An event input that is high in a cycle adds exactly one to its own accumulator. The accumulator value cannot be seen until the next tick.
- R3: On a tick edge, each snapshot takes its accumulator's value and the accumulator restarts, in the same edge. Between ticks the snapshots hold.
- R4: An event that arrives in the same cycle as a tick belongs to the new interval, so that accumulator restarts at one.
- R5: An accumulator at the all-ones value stays there while further events arrive; it never wraps.
- R6: clr_i high for one cycle zeroes every accumulator and snapshot. It wins over a tick and over events in the same cycle.
- R7: The per-lane snapshot for lane n is at byte address 0x070+4n for bad-type errors, 0x0D0+4n for CRC errors and 0x130+4n for framing errors. Each group has 24 slots.
- R8: The single counters are at 0x190 (receive burst, ev_single_i bit 0), 0x194 (general receive, bit 1), 0x198 (missing end-of-packet, bit 2), 0x19C (missing start-of-packet, bit 3) and 0x1A0 (transmit burst, bit 4).
- R9: A slot whose lane number is at or above NUM_LANES, and any address outside the two ranges above, reads zero.
- R10: rd_data_o shows the snapshot, zero-extended to 32 bits, for the address presented one cycle earlier. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear pulse for all counters |
| tick_i | input | 1 | Interval tick: snapshot and restart |
| ev_badtype_i | input | NUM_LANES | Bad block type event strobe per lane |
| ev_crc_i | input | NUM_LANES | CRC error event strobe per lane |
| ev_frame_i | input | NUM_LANES | Framing error event strobe per lane |
| ev_single_i | input | 5 | Link-wide event strobes, bit order as in R8 |
| rd_addr_i | input | ADDR_W | Byte read address |
| rd_data_o | output | 32 | Registered snapshot read data |

## Verification
A wrong accumulator cannot be seen at the ports until the next tick. It then shows on rd_data_o the first time its word is read, one cycle after its address is presented. A corrupted snapshot shows at the very next read of that word. The stimulus therefore sweeps the whole address space every 128 cycles against a behavioural model, with ticks spaced anywhere from every 3 cycles to every few dozen. With that spacing, any divergence shows within one interval plus one sweep. A bad lane or group decode shows as a nonzero value where a zero is due, or as the count of a different source.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int LANE_SLOTS    = 24;
    localparam int ERR_TYPES     = 3;
    localparam int SINGLE_CNT    = 5;
    localparam int LANE_BASE_W   = 'h070 / 4;
    localparam int SINGLE_BASE_W = 'h190 / 4;
    localparam int MAP_END_W     = SINGLE_BASE_W + SINGLE_CNT;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_EVENT,
        OP_TICK,
        OP_TICK_EVENT,
        OP_CLEAR
    } cnt_op_e;

    function automatic cnt_op_e pick_op(input logic clr, input logic tick, input logic ev);
        cnt_op_e op;
        if (clr)              op = OP_CLEAR;
        else if (tick && ev)  op = OP_TICK_EVENT;
        else if (tick)        op = OP_TICK;
        else if (ev)          op = OP_EVENT;
        else                  op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/evc_cell.sv
module evc_cell
    import evc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             ev_i,
    output logic [CNT_W-1:0] acc_o,
    output logic [CNT_W-1:0] snap_o
);

    localparam logic [CNT_W-1:0] SAT = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_op_e          op;
    logic [CNT_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0] snap_q, snap_d;

    // next-value process: one named operation per cycle
    always_comb begin
        op     = pick_op(clr_i, tick_i, ev_i);
        acc_d  = acc_q;
        snap_d = snap_q;
        unique case (op)
            OP_CLEAR: begin
                acc_d  = '0;
                snap_d = '0;
            end
            OP_TICK_EVENT: begin
                snap_d = acc_q;
                acc_d  = ONE;
            end
            OP_TICK: begin
                snap_d = acc_q;
                acc_d  = '0;
            end
            OP_EVENT: begin
                acc_d  = (acc_q == SAT) ? SAT : acc_q + ONE;
            end
            OP_IDLE: begin
                acc_d  = acc_q;
            end
        endcase
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            snap_q <= '0;
        end else begin
            acc_q  <= acc_d;
            snap_q <= snap_d;
        end
    end

    assign acc_o  = acc_q;
    assign snap_o = snap_q;

endmodule

// File: rtl/evc_bank.sv
module evc_bank #(
    parameter int NCNT  = 41,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  tick_i,
    input  logic [NCNT-1:0]       ev_i,
    output logic [NCNT*CNT_W-1:0] acc_flat_o,
    output logic [NCNT*CNT_W-1:0] snap_flat_o
);

    for (genvar i = 0; i < NCNT; i++) begin : g_cell
        evc_cell #(.CNT_W(CNT_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_i),
            .tick_i (tick_i),
            .ev_i   (ev_i[i]),
            .acc_o  (acc_flat_o[i*CNT_W +: CNT_W]),
            .snap_o (snap_flat_o[i*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/evc_rdmux.sv
module evc_rdmux
    import evc_pkg::*;
#(
    parameter int NUM_LANES = 12,
    parameter int CNT_W     = 32,
    parameter int NCNT      = 41,
    parameter int WORD_W    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     word_i,
    input  logic [NCNT*CNT_W-1:0] snap_flat_i,
    output logic [31:0]           rd_data_o
);

    localparam int IDX_W      = $clog2(NCNT);
    localparam int LANE_END_W = LANE_BASE_W + ERR_TYPES * LANE_SLOTS;

    logic [CNT_W-1:0] snap_arr [NCNT];
    logic [IDX_W-1:0] sel;
    logic             hit;
    logic [31:0]      rd_d;

    for (genvar i = 0; i < NCNT; i++) begin : g_unpack
        assign snap_arr[i] = snap_flat_i[i*CNT_W +: CNT_W];
    end

    always_comb begin
        int w;
        int off;
        int grp;
        int lane;
        int idx;
        w    = int'(word_i);
        off  = 0;
        grp  = 0;
        lane = 0;
        idx  = 0;
        hit  = 1'b0;
        if (w >= LANE_BASE_W && w < LANE_END_W) begin
            off  = w - LANE_BASE_W;
            grp  = off / LANE_SLOTS;
            lane = off % LANE_SLOTS;
            hit  = (lane < NUM_LANES);
            idx  = grp * NUM_LANES + lane;
        end else if (w >= SINGLE_BASE_W && w < MAP_END_W) begin
            hit  = 1'b1;
            idx  = ERR_TYPES * NUM_LANES + (w - SINGLE_BASE_W);
        end
        sel  = IDX_W'(idx);
        rd_d = '0;
        if (hit) rd_d[CNT_W-1:0] = snap_arr[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_o <= '0;
        else        rd_data_o <= rd_d;
    end

endmodule

// File: rtl/tick_err_counters.sv
module tick_err_counters
    import evc_pkg::*;
#(
    parameter int NUM_LANES = 12,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 tick_i,
    input  logic [NUM_LANES-1:0] ev_badtype_i,
    input  logic [NUM_LANES-1:0] ev_crc_i,
    input  logic [NUM_LANES-1:0] ev_frame_i,
    input  logic [4:0]           ev_single_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [31:0]          rd_data_o
);

    localparam int NCNT   = ERR_TYPES * NUM_LANES + SINGLE_CNT;
    localparam int WORD_W = ADDR_W - 2;

    logic [NCNT-1:0]       ev_all;
    logic [NCNT*CNT_W-1:0] acc_flat;
    logic [NCNT*CNT_W-1:0] snap_flat;
    logic                  unused_addr_lsb;

    // index = type * NUM_LANES + lane, single counters after the lanes
    assign ev_all          = {ev_single_i, ev_frame_i, ev_crc_i, ev_badtype_i};
    assign unused_addr_lsb = ^rd_addr_i[1:0];

    evc_bank #(.NCNT(NCNT), .CNT_W(CNT_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .tick_i      (tick_i),
        .ev_i        (ev_all),
        .acc_flat_o  (acc_flat),
        .snap_flat_o (snap_flat)
    );

    evc_rdmux #(
        .NUM_LANES (NUM_LANES),
        .CNT_W     (CNT_W),
        .NCNT      (NCNT),
        .WORD_W    (WORD_W)
    ) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_i      (rd_addr_i[ADDR_W-1:2]),
        .snap_flat_i (snap_flat),
        .rd_data_o   (rd_data_o)
    );

endmodule

// File: rtl/evc_checker.sv
module evc_checker
    import evc_pkg::*;
#(
    parameter int NUM_LANES = 12,
    parameter int CNT_W     = 32,
    parameter int NCNT      = 41,
    parameter int WORD_W    = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr_i,
    input logic                  tick_i,
    input logic                  ev0_i,
    input logic [WORD_W-1:0]     word_i,
    input logic [31:0]           rd_data_i,
    input logic [NCNT*CNT_W-1:0] acc_flat_i,
    input logic [NCNT*CNT_W-1:0] snap_flat_i
);

    localparam logic [CNT_W-1:0] SAT   = '1;
    localparam int               S0_LO = ERR_TYPES * NUM_LANES * CNT_W;

    logic [CNT_W-1:0] acc0;
    assign acc0 = acc_flat_i[S0_LO +: CNT_W];

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_flat_i == '0 && snap_flat_i == '0));

    p_tick_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i) |=> (snap_flat_i == $past(acc_flat_i)));

    p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(snap_flat_i));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev0_i && !tick_i && !clr_i && acc0 != SAT) |=> (acc0 == $past(acc0) + CNT_W'(1)));

    p_restart_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && ev0_i) |=> (acc0 == CNT_W'(1)));

    p_outside_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(word_i) >= MAP_END_W) |=> (rd_data_i == 32'd0));

    for (genvar i = 0; i < NCNT; i++) begin : g_sat
        p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_flat_i[i*CNT_W +: CNT_W] == SAT && !tick_i && !clr_i)
            |=> (acc_flat_i[i*CNT_W +: CNT_W] == SAT));
    end

endmodule

bind tick_err_counters evc_checker #(
    .NUM_LANES (NUM_LANES),
    .CNT_W     (CNT_W),
    .NCNT      (NCNT),
    .WORD_W    (WORD_W)
) u_evc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .tick_i      (tick_i),
    .ev0_i       (ev_single_i[0]),
    .word_i      (rd_addr_i[ADDR_W-1:2]),
    .rd_data_i   (rd_data_o),
    .acc_flat_i  (acc_flat),
    .snap_flat_i (snap_flat)
);

// File: tb/tb_tick_err_counters.sv
`timescale 1ns/1ps
module tb_tick_err_counters;

    localparam int NL   = 12;
    localparam int CW   = 8;
    localparam int AW   = 12;
    localparam int NC   = 3 * NL + 5;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          tick = 1'b0;
    logic [NL-1:0] e_bt = '0;
    logic [NL-1:0] e_crc = '0;
    logic [NL-1:0] e_fr = '0;
    logic [4:0]    e_s = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   rd;
    logic [NC-1:0] e_all;

    always #2.5 clk = ~clk;

    tick_err_counters #(.NUM_LANES(NL), .CNT_W(CW), .ADDR_W(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .tick_i       (tick),
        .ev_badtype_i (e_bt),
        .ev_crc_i     (e_crc),
        .ev_frame_i   (e_fr),
        .ev_single_i  (e_s),
        .rd_addr_i    (addr),
        .rd_data_o    (rd)
    );

    assign e_all = {e_s, e_fr, e_crc, e_bt};

    int          checks = 0;
    int          fails  = 0;
    string       phase  = "R1";
    bit          cmp_en = 1'b0;
    bit          done   = 1'b0;
    int unsigned m_acc  [NC];
    int unsigned m_snap [NC];
    logic [31:0] m_rd = '0;

    // expected read value from the model, by searching the address list
    function automatic logic [31:0] look(input int word);
        logic [31:0] v;
        v = '0;
        for (int t = 0; t < 3; t++)
            for (int l = 0; l < NL; l++)
                if (word == 28 + 24 * t + l) v = m_snap[t * NL + l];
        for (int k = 0; k < 5; k++)
            if (word == 100 + k) v = m_snap[3 * NL + k];
        return v;
    endfunction

    function automatic string region(input int word);
        if (word >= 28 && word < 100 && ((word - 28) % 24) < NL) return "R7";
        if (word >= 100 && word < 105) return "R8";
        return "R9";
    endfunction

    // behavioural reference model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = '0;
            for (int i = 0; i < NC; i++) begin m_acc[i] = 0; m_snap[i] = 0; end
        end else begin
            m_rd = look(int'(addr[AW-1:2]));
            for (int i = 0; i < NC; i++) begin
                if (clr) begin
                    m_acc[i] = 0; m_snap[i] = 0;
                end else if (tick) begin
                    m_snap[i] = m_acc[i];
                    m_acc[i]  = e_all[i] ? 1 : 0;
                end else if (e_all[i] && m_acc[i] < MAXV) begin
                    m_acc[i] = m_acc[i] + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (rd !== m_rd) begin
                fails++;
                $display("FAIL %s/%s addr=%h actual=%h expected=%h",
                         phase, region(int'(addr[AW-1:2])), addr, rd, m_rd);
            end
        end
    end

    task automatic quiet();
        e_bt = '0; e_crc = '0; e_fr = '0; e_s = '0; tick = 0; clr = 0;
    endtask

    task automatic cyc(input int n, input int prob, input int tper, input int cper);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            addr = AW'((i % 128) * 4 + int'($urandom % 4));
            for (int j = 0; j < NL; j++) begin
                e_bt[j]  = (($urandom % 100) < prob);
                e_crc[j] = (($urandom % 100) < prob);
                e_fr[j]  = (($urandom % 100) < prob);
            end
            for (int j = 0; j < 5; j++) e_s[j] = (($urandom % 100) < prob);
            tick = (tper > 0) && (i % tper == tper - 1);
            clr  = (cper > 0) && (i % cper == cper - 1);
        end
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        quiet();
        addr = a;
        @(negedge clk);
        checks++;
        if (rd !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        quiet();
        repeat (3) @(negedge clk);
        checks++;
        if (rd !== 32'd0) begin
            fails++;
            $display("FAIL R1 actual=%h expected=0", rd);
        end
        cmp_en = 1'b1;
        rst_n  = 1'b1;
        cyc(130, 0, 0, 0);

        phase = "R2";
        cyc(200, 40, 0, 0);
        cyc(1, 0, 1, 0);
        cyc(130, 0, 0, 0);

        phase = "R3";
        cyc(3000, 20, 37, 0);

        phase = "R4";
        cyc(2000, 60, 3, 0);

        phase = "R5";
        cyc(300, 100, 0, 0);
        cyc(1, 100, 1, 0);           // saturated values snapped, restart at one
        expect_rd(12'h070, MAXV, "R5");
        expect_rd(12'h15C, MAXV, "R7");
        expect_rd(12'h0D4, MAXV, "R7");
        expect_rd(12'h0A0, 0, "R9");
        expect_rd(12'h12C, 0, "R9");
        expect_rd(12'h1A0, MAXV, "R8");
        expect_rd(12'h198, MAXV, "R8");
        expect_rd(12'h1A4, 0, "R9");
        expect_rd(12'h073, MAXV, "R10");
        cyc(1, 0, 1, 0);
        expect_rd(12'h194, 1, "R4");
        expect_rd(12'h0D0, 1, "R4");

        phase = "R6";
        cyc(1, 100, 1, 1);           // clear beats tick and events
        expect_rd(12'h070, 0, "R6");
        cyc(1, 0, 1, 0);
        expect_rd(12'h190, 0, "R6");
        cyc(2000, 50, 25, 50);

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule